// File: doc/BRIEF.md
# Configuration Variable Store

This block holds the configuration variables of a track decoder in a small register file that comes up with factory defaults. Other logic sends it requests that carry a CV number, a data byte, a write flag and a request kind. The block answers a read with the stored value. It applies a per-variable legality rule to each write and accepts the write only if the rule passes. Every stored value also drives a parallel output, so the motor, address-match and consist logic can use it directly.

Illegal writes are dropped without any reply. CV numbers that the block does not implement get no acknowledge. The two-byte extended address must be written high byte first: the high byte waits in a staging register and both bytes are committed when the low byte arrives. A new primary address clears the consist address and the extended-address enable. A paged request finds its CV through an 8-bit page register, and the page register returns to 1 after every paged request.

The request side is a valid/ready port. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then drops for exactly one cycle, so requests can be accepted at most every second cycle. The requester must hold its request stable until it is taken. The answer is the single-cycle `rsp_ack` pulse, and for reads it comes with `rsp_data`.

Top module: `cv_store`

## Requirements
- R1: After reset the outputs hold their defaults: primary address 3, start level 7, PWM setting 180, extended address 0xC003, configuration 0x02, page register 1, and every other output 0. A read of CV 8 returns 141 and a read of CV 7 returns the version parameter (default 0x11).
- R2: A write to CV 1 is accepted only for values 1 to 127. An accepted CV 1 write also sets CV 19 to 0 and clears bit 5 of CV 29, and leaves the other bits of CV 29 as they were.
- R3: A write to CV 9 with a value above 230 is ignored. Values 0 to 230 are accepted.
- R4: A write to CV 17 with a value from 0xC0 to 0xE7 is acknowledged and goes into a staging register only. The extended-address output and reads of CV 17 keep the committed value until a CV 18 write commits the staged high byte and the new low byte together. The output shows the high byte in bits 15:8 and the low byte in bits 7:0.
- R5: The following CV 17 and CV 18 writes are ignored and get no acknowledge: a CV 17 write outside 0xC0 to 0xE7, which leaves any earlier staged byte pending, and a CV 18 write with nothing staged. A commit empties the staging register.
- R6: CV 7 and CV 8 are read-only. Writes to them get no acknowledge and change nothing.
- R7: Only CVs 1, 2, 3, 4, 7, 8, 9, 11, 17, 18, 19, 21 and 29 exist. A read or write of any other number gets no acknowledge and changes nothing.
- R8: One cycle after a request is taken, `rsp_ack` is high for exactly one cycle if the request was an accepted write or a read of an existing CV. For reads, `rsp_data` holds the value in that same cycle. `req_ready` is low in the cycle after each acceptance.
- R9: The request kind is set by `req_kind`. Value 0 means direct: the CV number is `req_cv`. Value 1 means paged: the CV number is 4×(page−1) + `req_cv[1:0]` + 1. Value 2 means a page-register access, which reads or writes the page (any value, always acknowledged). Value 3 is never acknowledged. Every paged request leaves the page at 1 afterwards, whether or not it is acknowledged.
- R10: Writes to CVs 2, 3, 4, 11, 19, 21 and 29 accept any byte value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_kind | input | 2 | 0 direct, 1 paged, 2 page register, 3 reserved |
| req_write | input | 1 | 1 write, 0 read |
| req_cv | input | CV_W | CV number (direct) or register offset (paged, bits 1:0) |
| req_data | input | DATA_W | Write data |
| rsp_ack | output | 1 | Single-cycle acknowledge |
| rsp_data | output | DATA_W | Read data, valid with the acknowledge of a read |
| cv_primary | output | DATA_W | Primary address |
| cv_start | output | DATA_W | Start level |
| cv_accel | output | DATA_W | Acceleration rate |
| cv_brake | output | DATA_W | Braking rate |
| cv_pwm | output | DATA_W | PWM period setting |
| cv_timeout | output | DATA_W | Packet timeout |
| cv_ext_addr | output | 2*DATA_W | Committed extended address |
| cv_consist | output | DATA_W | Consist address and direction |
| cv_consist_fn | output | DATA_W | Consist function enables |
| cv_config | output | DATA_W | Configuration byte |
| cv_page | output | 8 | Page register |

## Verification
The assertions assume that the requester holds its request stable until it is taken and never changes `req_kind` in the middle of a request. They also assume that the only way to reach the stored values is through this port, which is why the range checks on the primary address, the PWM setting and the extended high byte can hold at all times. The bench drives each request at a falling edge while `req_ready` is high and drops `req_valid` right after the request is taken, so it always stays within those assumptions. Its random kinds, CV numbers and data are weighted towards the range edges (0, 1, 127, 128, 230, 231, 0xBF, 0xC0, 0xE7, 0xE8) and towards the CV 17/18 pair.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

  typedef enum logic [1:0] {
    KIND_DIRECT = 2'd0,
    KIND_PAGED  = 2'd1,
    KIND_PAGE   = 2'd2,
    KIND_RSVD   = 2'd3
  } req_kind_t;

  typedef enum logic [3:0] {
    SL_PRIM  = 4'd0,
    SL_START = 4'd1,
    SL_ACCEL = 4'd2,
    SL_BRAKE = 4'd3,
    SL_VER   = 4'd4,
    SL_MFG   = 4'd5,
    SL_PWM   = 4'd6,
    SL_TMO   = 4'd7,
    SL_EXTH  = 4'd8,
    SL_EXTL  = 4'd9,
    SL_CONS  = 4'd10,
    SL_CFN   = 4'd11,
    SL_CFG   = 4'd12
  } slot_t;

  localparam int NUM_SLOTS   = 13;
  localparam int CFG_EXT_BIT = 5;

  localparam int CVN_PRIM  = 1;
  localparam int CVN_START = 2;
  localparam int CVN_ACCEL = 3;
  localparam int CVN_BRAKE = 4;
  localparam int CVN_VER   = 7;
  localparam int CVN_MFG   = 8;
  localparam int CVN_PWM   = 9;
  localparam int CVN_TMO   = 11;
  localparam int CVN_EXTH  = 17;
  localparam int CVN_EXTL  = 18;
  localparam int CVN_CONS  = 19;
  localparam int CVN_CFN   = 21;
  localparam int CVN_CFG   = 29;

endpackage

// File: rtl/cvs_decode.sv
module cvs_decode
  import cvs_pkg::*;
#(
  parameter int CV_W = 10
) (
  input  logic [1:0]      kind,
  input  logic [CV_W-1:0] cv,
  input  logic [7:0]      page,
  output logic            hit,
  output logic            is_page,
  output slot_t           slot
);

  logic [CV_W-1:0] eff_cv;
  logic [CV_W-1:0] page_base;
  logic            map_hit;

  always_comb begin
    page_base = CV_W'({page, 2'b00});
    if (req_kind_t'(kind) == KIND_PAGED)
      eff_cv = page_base - CV_W'(3) + CV_W'(cv[1:0]);
    else
      eff_cv = cv;
  end

  always_comb begin
    map_hit = 1'b1;
    slot    = SL_PRIM;
    case (eff_cv)
      CV_W'(CVN_PRIM):  slot = SL_PRIM;
      CV_W'(CVN_START): slot = SL_START;
      CV_W'(CVN_ACCEL): slot = SL_ACCEL;
      CV_W'(CVN_BRAKE): slot = SL_BRAKE;
      CV_W'(CVN_VER):   slot = SL_VER;
      CV_W'(CVN_MFG):   slot = SL_MFG;
      CV_W'(CVN_PWM):   slot = SL_PWM;
      CV_W'(CVN_TMO):   slot = SL_TMO;
      CV_W'(CVN_EXTH):  slot = SL_EXTH;
      CV_W'(CVN_EXTL):  slot = SL_EXTL;
      CV_W'(CVN_CONS):  slot = SL_CONS;
      CV_W'(CVN_CFN):   slot = SL_CFN;
      CV_W'(CVN_CFG):   slot = SL_CFG;
      default:          map_hit = 1'b0;
    endcase
  end

  assign is_page = (req_kind_t'(kind) == KIND_PAGE);
  assign hit     = map_hit && ((req_kind_t'(kind) == KIND_DIRECT) ||
                               (req_kind_t'(kind) == KIND_PAGED));

endmodule

// File: rtl/cvs_rules.sv
module cvs_rules
  import cvs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PWM_MAX    = 230,
  parameter int EXT_HI_MIN = 'hC0,
  parameter int EXT_HI_MAX = 'hE7
) (
  input  slot_t             slot,
  input  logic [DATA_W-1:0] data,
  input  logic              stage_ok,
  output logic              wr_ok,
  output logic              stage_load,
  output logic              pair_commit
);

  always_comb begin
    wr_ok       = 1'b1;
    stage_load  = 1'b0;
    pair_commit = 1'b0;
    case (slot)
      SL_PRIM: wr_ok = (data >= DATA_W'(1)) && (data <= DATA_W'(127));
      SL_VER,
      SL_MFG:  wr_ok = 1'b0;
      SL_PWM:  wr_ok = (data <= DATA_W'(PWM_MAX));
      SL_EXTH: begin
        wr_ok      = (data >= DATA_W'(EXT_HI_MIN)) && (data <= DATA_W'(EXT_HI_MAX));
        stage_load = wr_ok;
      end
      SL_EXTL: begin
        wr_ok       = stage_ok;
        pair_commit = stage_ok;
      end
      default: wr_ok = 1'b1;
    endcase
  end

endmodule

// File: rtl/cvs_regs.sv
module cvs_regs #(
  parameter int NUM    = 13,
  parameter int DATA_W = 8,
  parameter logic [NUM-1:0][DATA_W-1:0] DEFS = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM-1:0]             we,
  input  logic [NUM-1:0][DATA_W-1:0] wd,
  output logic [NUM-1:0][DATA_W-1:0] q
);

  for (genvar g = 0; g < NUM; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[g] <= DEFS[g];
      else if (we[g]) q[g] <= wd[g];
    end
  end

endmodule

// File: rtl/cv_store.sv
module cv_store
  import cvs_pkg::*;
#(
  parameter int CV_W        = 10,
  parameter int DATA_W      = 8,
  parameter int DEF_PRIMARY = 3,
  parameter int DEF_START   = 7,
  parameter int DEF_PWM     = 180,
  parameter int DEF_EXT     = 'hC003,
  parameter int DEF_CONFIG  = 'h02,
  parameter int VERSION_ID  = 'h11,
  parameter int MFG_ID      = 141,
  parameter int PWM_MAX     = 230,
  parameter int EXT_HI_MIN  = 'hC0,
  parameter int EXT_HI_MAX  = 'hE7,
  parameter int PAGE_DEF    = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_kind,
  input  logic                req_write,
  input  logic [CV_W-1:0]     req_cv,
  input  logic [DATA_W-1:0]   req_data,
  output logic                rsp_ack,
  output logic [DATA_W-1:0]   rsp_data,
  output logic [DATA_W-1:0]   cv_primary,
  output logic [DATA_W-1:0]   cv_start,
  output logic [DATA_W-1:0]   cv_accel,
  output logic [DATA_W-1:0]   cv_brake,
  output logic [DATA_W-1:0]   cv_pwm,
  output logic [DATA_W-1:0]   cv_timeout,
  output logic [2*DATA_W-1:0] cv_ext_addr,
  output logic [DATA_W-1:0]   cv_consist,
  output logic [DATA_W-1:0]   cv_consist_fn,
  output logic [DATA_W-1:0]   cv_config,
  output logic [7:0]          cv_page
);

  localparam int EXT_W = 2 * DATA_W;

  function automatic logic [NUM_SLOTS-1:0][DATA_W-1:0] build_defs();
    logic [NUM_SLOTS-1:0][DATA_W-1:0] d;
    logic [EXT_W-1:0] ext;
    d = '0;
    ext = EXT_W'(DEF_EXT);
    d[SL_PRIM]  = DATA_W'(DEF_PRIMARY);
    d[SL_START] = DATA_W'(DEF_START);
    d[SL_VER]   = DATA_W'(VERSION_ID);
    d[SL_MFG]   = DATA_W'(MFG_ID);
    d[SL_PWM]   = DATA_W'(DEF_PWM);
    d[SL_EXTH]  = ext[EXT_W-1:DATA_W];
    d[SL_EXTL]  = ext[DATA_W-1:0];
    d[SL_CFG]   = DATA_W'(DEF_CONFIG);
    return d;
  endfunction

  localparam logic [NUM_SLOTS-1:0][DATA_W-1:0] DEFS = build_defs();

  logic                               fire;
  logic                               hit, is_page;
  slot_t                              slot;
  logic                               wr_ok, stage_load, pair_commit;
  logic                               accept, rd_fire;
  logic                               stage_ok;
  logic [DATA_W-1:0]                  stage_val;
  logic [7:0]                         page_q;
  logic [NUM_SLOTS-1:0]               we;
  logic [NUM_SLOTS-1:0][DATA_W-1:0]   wd;
  logic [NUM_SLOTS-1:0][DATA_W-1:0]   q;

  assign fire    = req_valid && req_ready;
  assign accept  = fire && req_write && hit && wr_ok;
  assign rd_fire = fire && !req_write && hit;

  cvs_decode #(.CV_W(CV_W)) u_decode (
    .kind    (req_kind),
    .cv      (req_cv),
    .page    (page_q),
    .hit     (hit),
    .is_page (is_page),
    .slot    (slot)
  );

  cvs_rules #(
    .DATA_W     (DATA_W),
    .PWM_MAX    (PWM_MAX),
    .EXT_HI_MIN (EXT_HI_MIN),
    .EXT_HI_MAX (EXT_HI_MAX)
  ) u_rules (
    .slot        (slot),
    .data        (req_data),
    .stage_ok    (stage_ok),
    .wr_ok       (wr_ok),
    .stage_load  (stage_load),
    .pair_commit (pair_commit)
  );

  always_comb begin
    we = '0;
    for (int i = 0; i < NUM_SLOTS; i++) wd[i] = req_data;
    if (accept) begin
      if (pair_commit) begin
        we[SL_EXTH] = 1'b1;
        wd[SL_EXTH] = stage_val;
        we[SL_EXTL] = 1'b1;
      end else if (!stage_load) begin
        we[slot] = 1'b1;
      end
      if (slot == SL_PRIM) begin
        we[SL_CONS] = 1'b1;
        wd[SL_CONS] = '0;
        we[SL_CFG]  = 1'b1;
        wd[SL_CFG]  = q[SL_CFG] & ~(DATA_W'(1) << CFG_EXT_BIT);
      end
    end
  end

  cvs_regs #(
    .NUM    (NUM_SLOTS),
    .DATA_W (DATA_W),
    .DEFS   (DEFS)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .wd    (wd),
    .q     (q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_ok  <= 1'b0;
      stage_val <= '0;
    end else if (accept && stage_load) begin
      stage_ok  <= 1'b1;
      stage_val <= req_data;
    end else if (accept && pair_commit) begin
      stage_ok  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= 8'(PAGE_DEF);
    end else if (fire && is_page && req_write) begin
      page_q <= req_data[7:0];
    end else if (fire && req_kind_t'(req_kind) == KIND_PAGED) begin
      page_q <= 8'(PAGE_DEF);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ready <= 1'b1;
      rsp_ack   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      req_ready <= !fire;
      rsp_ack   <= accept || rd_fire || (fire && is_page);
      if (rd_fire)
        rsp_data <= q[slot];
      else if (fire && is_page && !req_write)
        rsp_data <= DATA_W'(page_q);
    end
  end

  assign cv_primary    = q[SL_PRIM];
  assign cv_start      = q[SL_START];
  assign cv_accel      = q[SL_ACCEL];
  assign cv_brake      = q[SL_BRAKE];
  assign cv_pwm        = q[SL_PWM];
  assign cv_timeout    = q[SL_TMO];
  assign cv_ext_addr   = {q[SL_EXTH], q[SL_EXTL]};
  assign cv_consist    = q[SL_CONS];
  assign cv_consist_fn = q[SL_CFN];
  assign cv_config     = q[SL_CFG];
  assign cv_page       = page_q;

  AST_ACK_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> $past(fire)) else $error("ack without request"); // R8

  AST_READY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !req_ready) else $error("ready high after acceptance"); // R8

  AST_PRIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_primary >= DATA_W'(1)) && (cv_primary <= DATA_W'(127))) else $error("primary out of range"); // R2

  AST_PRIM_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write && hit && slot == SL_PRIM && req_data != '0 && req_data <= DATA_W'(127))
    |=> (cv_consist == '0) && !cv_config[CFG_EXT_BIT]) else $error("primary side effect missing"); // R2

  AST_PWM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cv_pwm <= DATA_W'(PWM_MAX)) else $error("pwm out of range"); // R3

  AST_EXT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_ext_addr[EXT_W-1:DATA_W] >= DATA_W'(EXT_HI_MIN)) &&
    (cv_ext_addr[EXT_W-1:DATA_W] <= DATA_W'(EXT_HI_MAX))) else $error("ext high out of range"); // R4

  AST_EXT_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && req_write && hit && slot == SL_EXTL) |=> $stable(cv_ext_addr)) else $error("ext changed without low write"); // R5

  AST_PAGE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_kind_t'(req_kind) == KIND_PAGED) |=> (cv_page == 8'(PAGE_DEF))) else $error("page not reset"); // R9

  AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_kind_t'(req_kind) == KIND_RSVD) |=> !rsp_ack) else $error("reserved kind acked"); // R9

endmodule

// File: tb/test_cv_store.sv
module test_cv_store;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic        req_write = 1'b0;
  logic [9:0]  req_cv = '0;
  logic [7:0]  req_data = '0;
  logic        rsp_ack;
  logic [7:0]  rsp_data;
  logic [7:0]  cv_primary, cv_start, cv_accel, cv_brake, cv_pwm, cv_timeout;
  logic [15:0] cv_ext_addr;
  logic [7:0]  cv_consist, cv_consist_fn, cv_config, cv_page;

  int tests = 0;
  int fails = 0;

  logic [7:0] mdl [0:31];
  logic [7:0] m_page;
  logic [7:0] m_stage;
  logic       m_stage_ok;

  always #10 clk = ~clk;

  cv_store i_cv_store (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_write(req_write), .req_cv(req_cv), .req_data(req_data),
    .rsp_ack(rsp_ack), .rsp_data(rsp_data), .cv_primary(cv_primary), .cv_start(cv_start),
    .cv_accel(cv_accel), .cv_brake(cv_brake), .cv_pwm(cv_pwm), .cv_timeout(cv_timeout),
    .cv_ext_addr(cv_ext_addr), .cv_consist(cv_consist), .cv_consist_fn(cv_consist_fn),
    .cv_config(cv_config), .cv_page(cv_page)
  );

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exists(int cv);
    case (cv)
      1, 2, 3, 4, 7, 8, 9, 11, 17, 18, 19, 21, 29: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_outputs(string req);
    check(req, "primary", cv_primary, mdl[1]);
    check(req, "start", cv_start, mdl[2]);
    check(req, "pwm", cv_pwm, mdl[9]);
    check(req, "ext", cv_ext_addr, {mdl[17], mdl[18]});
    check(req, "consist", cv_consist, mdl[19]);
    check(req, "config", cv_config, mdl[29]);
    check(req, "page", cv_page, m_page);
  endtask

  task automatic do_req(string req, int kind, int cv, bit wr, int data);
    bit exp_ack = 1'b0;
    int exp_rd  = -1;
    int e;
    logic [7:0] d = 8'(data);
    if (kind == 2) begin
      exp_ack = 1'b1;
      if (wr) m_page = d; else exp_rd = m_page;
    end else if (kind == 0 || kind == 1) begin
      e = (kind == 1) ? int'(10'({m_page, 2'b00} - 10'd3 + 10'(cv & 3))) : cv;
      if (kind == 1) m_page = 8'd1;
      if (exists(e)) begin
        if (!wr) begin
          exp_ack = 1'b1;
          exp_rd  = mdl[e];
        end else begin
          case (e)
            1: if (d >= 1 && d <= 127) begin
                 exp_ack = 1'b1; mdl[1] = d; mdl[19] = 8'h00; mdl[29][5] = 1'b0;
               end
            7, 8: exp_ack = 1'b0;
            9: if (d <= 230) begin exp_ack = 1'b1; mdl[9] = d; end
            17: if (d >= 8'hC0 && d <= 8'hE7) begin
                  exp_ack = 1'b1; m_stage = d; m_stage_ok = 1'b1;
                end
            18: if (m_stage_ok) begin
                  exp_ack = 1'b1; mdl[17] = m_stage; mdl[18] = d; m_stage_ok = 1'b0;
                end
            default: begin exp_ack = 1'b1; mdl[e] = d; end
          endcase
        end
      end
    end
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_kind = 2'(kind); req_cv = 10'(cv);
    req_write = wr; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R8"}, "ack", rsp_ack, exp_ack);
    check("R8", "ready gap", req_ready, 0);
    if (exp_rd >= 0) check({req, " R8"}, "read data", rsp_data, exp_rd);
    check_outputs(req);
    @(negedge clk);
    check("R8", "ack width", rsp_ack, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int pick [20] = '{1, 2, 3, 4, 7, 8, 9, 11, 17, 18, 19, 21, 29, 0, 5, 6, 10, 12, 30, 100};
    int edges [10] = '{0, 1, 127, 128, 230, 231, 'hBF, 'hC0, 'hE7, 'hE8};
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    mdl[1] = 8'd3; mdl[2] = 8'd7; mdl[7] = 8'h11; mdl[8] = 8'd141; mdl[9] = 8'd180;
    mdl[17] = 8'hC0; mdl[18] = 8'h03; mdl[29] = 8'h02;
    m_page = 8'd1; m_stage = 8'h00; m_stage_ok = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_outputs("R1");
    check("R1", "ready", req_ready, 1);
    check("R1", "ack", rsp_ack, 0);
    do_req("R1", 0, 8, 0, 0);
    do_req("R1", 0, 7, 0, 0);
    // R6 read-only
    do_req("R6", 0, 8, 1, 5);
    do_req("R6", 0, 7, 1, 9);
    do_req("R6", 0, 8, 0, 0);
    // R2 primary range and side effects
    do_req("R10", 0, 19, 1, 'h85);
    do_req("R10", 0, 29, 1, 'h26);
    do_req("R2", 0, 1, 1, 0);
    do_req("R2", 0, 1, 1, 128);
    do_req("R2", 0, 1, 1, 127);
    do_req("R2", 0, 1, 1, 1);
    // R3 pwm bound
    do_req("R3", 0, 9, 1, 231);
    do_req("R3", 0, 9, 1, 230);
    do_req("R3", 0, 9, 1, 0);
    // R4 R5 extended pair
    do_req("R5", 0, 18, 1, 'h44);
    do_req("R5", 0, 17, 1, 'hBF);
    do_req("R5", 0, 17, 1, 'hE8);
    do_req("R4", 0, 17, 1, 'hD0);
    do_req("R4", 0, 17, 0, 0);
    do_req("R5", 0, 17, 1, 'hE8);
    do_req("R4", 0, 18, 1, 'h45);
    do_req("R5", 0, 18, 1, 'h46);
    do_req("R4", 0, 17, 1, 'hE7);
    do_req("R4", 0, 18, 1, 'hFF);
    // R7 unknown numbers
    do_req("R7", 0, 5, 0, 0);
    do_req("R7", 0, 30, 1, 3);
    do_req("R7", 0, 1000, 0, 0);
    // R9 paging
    do_req("R9", 2, 0, 1, 3);
    do_req("R9", 2, 0, 0, 0);
    do_req("R9", 1, 2, 0, 0);
    do_req("R9", 1, 0, 1, 77);
    do_req("R9", 2, 0, 1, 9);
    do_req("R9", 1, 1, 1, 5);
    do_req("R9", 3, 1, 0, 0);
    do_req("R10", 0, 21, 1, 'hFF);
    do_req("R10", 0, 11, 1, 'h00);
    // random mix
    for (int n = 0; n < 600; n++) begin
      int k = ($urandom % 8 == 0) ? 2 : (($urandom % 5 == 0) ? 1 : 0);
      int c = (k == 1) ? int'($urandom % 4) : pick[$urandom % 20];
      int dv = ($urandom % 3 == 0) ? edges[$urandom % 10] : int'($urandom % 256);
      if (k == 2 && $urandom % 2 == 0) dv = 1 + ($urandom % 8);
      if ($urandom % 40 == 0) k = 3;
      do_req("R10", k, c, 1'($urandom % 2), dv);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule